// File: doc/BRIEF.md
# Bi-phase Infrared Remote Frame Decoder

This block takes the demodulated output of an infrared receiver (idle high, low while carrier is present) and recovers 14-bit bi-phase remote-control frames. A frame carries two start bits, a toggle bit, a 5-bit address and a 6-bit command. Each bit holds its value in the first half and the opposite level in the second half, so every bit has a transition at its middle. Decoding starts on the first input edge, which falls in the middle of the first start bit. The block then samples each later bit one quarter of the way into it. It measures the bit period again on every mid-bit edge, so a remote running fast or slow, or drifting within a frame, is still decoded correctly.

A frame that loses its mid-bit edges is abandoned without any output. A completed frame yields a 7-bit command, a 5-bit address and the toggle bit, marked by a one-cycle valid pulse. The seventh command bit is the inverse of the second start bit. A frame whose toggle bit equals the one last reported is taken as a held key and dropped. Time is kept in microseconds, derived from the clock by a prescaler.

Top module: `ir_biphase_decoder`

## Requirements
- R1: After reset, code_valid_o is 0, command_o, address_o and toggle_o are 0, and the stored toggle bit is 0. A first frame whose toggle bit is 0 is therefore treated as a repeat.
- R2: In idle, any edge on the synchronised input starts a frame. The first sample is taken 3/4 of the nominal bit period (BIT_US microseconds) after that edge.
- R3: Thirteen samples are taken, one at the first quarter of each bit after the first start bit. The sampled level is the bit value, and the order is second start bit, toggle, address bits 4 down to 0, then command bits 5 down to 0. address_o[4] is the first address bit received and command_o[5] is the first command bit received.
- R4: command_o[6] is the inverse of the sampled second start bit, and command_o[5:0] are the six received command bits.
- R5: After each sample except the last, the next input edge ends a period measurement. The elapsed microseconds since the previous restart become the new period estimate, the timer restarts from that edge, and the next sample falls 3/4 of the new estimate later. Frames whose bit period differs from nominal by ±15 %, or drifts by several percent per bit, decode correctly.
- R6: If no edge arrives within 3/2 of the current estimate after the last restart, the frame is abandoned. No output is given, the stored toggle bit is unchanged, and the decoder returns to idle ready for the next frame.
- R7: A completed frame whose toggle bit equals the stored toggle bit produces no valid pulse and leaves the outputs unchanged. Otherwise the stored bit takes the new toggle value and the code is reported.
- R8: code_valid_o is high for exactly one cycle per reported frame, about 3/4 of a bit period after the final mid-bit edge. command_o, address_o and toggle_o hold their values between reports.
- R9: After the last sample, input edges are ignored until 2 estimated periods have passed since the final restart. The remaining mid-bit and trailing edges of the frame therefore start no new decode, and a frame that follows with a short gap is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_i | input | 1 | Demodulated receiver output, idle high, asynchronous |
| code_valid_o | output | 1 | One-cycle pulse marking a newly reported code |
| command_o | output | 7 | Command, bit 6 being the inverted second start bit |
| address_o | output | 5 | Device address |
| toggle_o | output | 1 | Toggle bit of the reported frame |

## Verification
The valid pulse is due 3/4 of a measured bit period after the final mid-bit edge, plus about four cycles through the synchroniser, the frame register and the output register. The bench notes the cycle of that last mid-bit edge and requires the pulse to land within a small window around this point. For a suppressed or abandoned frame the bench waits two full bit periods past the end of the stimulus, which is longer than the decoder's guard and timeout windows. It then checks that no pulse appeared and that the outputs did not move. Each frame is followed by an idle gap of at least two periods before any result is read, except in the back-to-back case, where the gap is chosen to fall just after the guard window.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_EDGE   = 2'd2,
    ST_GUARD  = 2'd3
  } dec_state_t;

  // samples taken after the first start bit
  localparam int unsigned FRAME_SAMPLES = 13;
  localparam int unsigned ADDR_W        = 5;
  localparam int unsigned CMDLO_W       = 6;
  localparam int unsigned CMD_W         = CMDLO_W + 1;

  // positions inside the shifted sample word (first sample ends at MSB)
  localparam int unsigned POS_FIELD = FRAME_SAMPLES - 1;
  localparam int unsigned POS_TOG   = FRAME_SAMPLES - 2;
  localparam int unsigned POS_ADDR  = CMDLO_W;

endpackage

// File: rtl/irdec_sync_edge.sv
module irdec_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic lvl_o,
  output logic edge_o
);

  logic meta_q, sync_q, last_q;

  // reset to the idle (high) line level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      last_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign edge_o = sync_q ^ last_q;

endmodule

// File: rtl/irdec_us_timer.sv
module irdec_us_timer #(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned CNT_W       = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (CLKS_PER_US > 1) begin : g_pre
      localparam int unsigned PRE_W = $clog2(CLKS_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
      logic [PRE_W-1:0] pre_q, pre_d;

      assign tick = (pre_q == PRE_LAST);

      always_comb begin
        if (clr_i || tick) pre_d = '0;
        else               pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // saturating microsecond count
  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                         cnt_d = '0;
    else if (tick && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R5
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !clr_i) |=> (count_o == CNT_MAX));

endmodule

// File: rtl/irdec_frame_fsm.sv
module irdec_frame_fsm
  import irdec_pkg::*;
#(
  parameter int unsigned BIT_US = 1778,
  parameter int unsigned CNT_W  = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lvl_i,
  input  logic                     edge_i,
  input  logic [CNT_W-1:0]         tmr_i,
  output logic                     tmr_clr_o,
  output logic                     done_o,
  output logic [FRAME_SAMPLES-1:0] bits_o
);

  localparam int unsigned IDX_W = $clog2(FRAME_SAMPLES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_SAMPLES - 1);
  localparam logic [CNT_W:0]   TMAX_W   = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] NOM_EST  = CNT_W'(BIT_US);
  localparam logic [CNT_W-1:0] MIN_EST  = CNT_W'(4);

  dec_state_t               state_q, state_d;
  logic [CNT_W-1:0]         est_q, est_d;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic [FRAME_SAMPLES-1:0] sh_q, sh_d;
  logic                     done_q, done_d;

  // timing points derived from the current period estimate
  logic [CNT_W:0]   est_w, to_sum, grd_sum;
  logic [CNT_W-1:0] smp_at, to_at, grd_at;

  always_comb begin
    est_w   = {1'b0, est_q};
    smp_at  = (est_q >> 1) + (est_q >> 2);
    to_sum  = est_w + (est_w >> 1);
    grd_sum = est_w << 1;
    to_at   = (to_sum  > TMAX_W) ? {CNT_W{1'b1}} : to_sum[CNT_W-1:0];
    grd_at  = (grd_sum > TMAX_W) ? {CNT_W{1'b1}} : grd_sum[CNT_W-1:0];
  end

  always_comb begin
    state_d   = state_q;
    est_d     = est_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    done_d    = 1'b0;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (edge_i) begin
          state_d   = ST_SAMPLE;
          est_d     = NOM_EST;
          idx_d     = '0;
          tmr_clr_o = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (tmr_i >= smp_at) begin
          sh_d  = {sh_q[FRAME_SAMPLES-2:0], lvl_i};
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            done_d  = 1'b1;
            state_d = ST_GUARD;
          end else begin
            state_d = ST_EDGE;
          end
        end
      end
      ST_EDGE: begin
        if (edge_i) begin
          est_d     = (tmr_i < MIN_EST) ? MIN_EST : tmr_i;
          tmr_clr_o = 1'b1;
          state_d   = ST_SAMPLE;
        end else if (tmr_i >= to_at) begin
          state_d = ST_IDLE;
        end
      end
      ST_GUARD: begin
        if (tmr_i >= grd_at) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      est_q   <= NOM_EST;
      idx_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      est_q   <= est_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign bits_o = sh_q;

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && edge_i) |=> (state_q == ST_SAMPLE && tmr_i == '0));

  // R5
  sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMPLE) |-> (tmr_i <= smp_at));

  // R6
  edge_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EDGE) |-> (tmr_i <= to_at));

  // R9
  guard_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GUARD && edge_i) |=> (state_q != ST_SAMPLE));

endmodule

// File: rtl/irdec_repeat_filter.sv
module irdec_repeat_filter
  import irdec_pkg::*;
#(
  parameter int unsigned NB = FRAME_SAMPLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [NB-1:0]     bits_i,
  output logic              valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tog_o
);

  logic              held_q, held_d;
  logic              valid_q, valid_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              tog_q, tog_d;
  logic              fresh;

  assign fresh = done_i && (bits_i[POS_TOG] != held_q);

  always_comb begin
    held_d  = held_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    tog_d   = tog_q;
    valid_d = 1'b0;
    if (fresh) begin
      valid_d = 1'b1;
      held_d  = bits_i[POS_TOG];
      tog_d   = bits_i[POS_TOG];
      addr_d  = bits_i[POS_ADDR +: ADDR_W];
      cmd_d   = {~bits_i[POS_FIELD], bits_i[CMDLO_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      valid_q <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      tog_q   <= 1'b0;
    end else begin
      held_q  <= held_d;
      valid_q <= valid_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      tog_q   <= tog_d;
    end
  end

  assign valid_o = valid_q;
  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign tog_o   = tog_q;

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7
  repeat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && bits_i[POS_TOG] == held_q) |=> (!valid_o && $stable(cmd_o) && $stable(addr_o)));

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> ($stable(cmd_o) && $stable(addr_o) && $stable(tog_o)));

endmodule

// File: rtl/ir_biphase_decoder.sv
module ir_biphase_decoder
  import irdec_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned BIT_US      = 1778
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_rx_i,
  output logic              code_valid_o,
  output logic [CMD_W-1:0]  command_o,
  output logic [ADDR_W-1:0] address_o,
  output logic              toggle_o
);

  localparam int unsigned CNT_W = $clog2(4 * BIT_US);

  logic                     lvl, edge_seen, tmr_clr, frame_done;
  logic [CNT_W-1:0]         tmr;
  logic [FRAME_SAMPLES-1:0] frame_bits;

  irdec_sync_edge u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (ir_rx_i),
    .lvl_o  (lvl),
    .edge_o (edge_seen)
  );

  irdec_us_timer #(
    .CLKS_PER_US (CLKS_PER_US),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .count_o (tmr)
  );

  irdec_frame_fsm #(
    .BIT_US (BIT_US),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl),
    .edge_i    (edge_seen),
    .tmr_i     (tmr),
    .tmr_clr_o (tmr_clr),
    .done_o    (frame_done),
    .bits_o    (frame_bits)
  );

  irdec_repeat_filter #(
    .NB (FRAME_SAMPLES)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (frame_done),
    .bits_i  (frame_bits),
    .valid_o (code_valid_o),
    .cmd_o   (command_o),
    .addr_o  (address_o),
    .tog_o   (toggle_o)
  );

endmodule

// File: tb/sim_ir_biphase_decoder.sv
`timescale 1ns/1ps
module sim_ir_biphase_decoder;

  localparam int CPU = 2;
  localparam int BUS = 100;
  localparam int T   = CPU * BUS;   // nominal bit period in cycles

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic       vld;
  logic [6:0] cmd;
  logic [4:0] adr;
  logic       tog;

  ir_biphase_decoder #(.CLKS_PER_US(CPU), .BIT_US(BUS)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .ir_rx_i      (rx),
    .code_valid_o (vld),
    .command_o    (cmd),
    .address_o    (adr),
    .toggle_o     (tog)
  );

  always #10 clk = ~clk;

  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  int  nv = 0;
  int  wide = 0;
  int  t_v = 0;
  int  t_mid = 0;
  bit  prev_v = 1'b0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (vld) begin
      nv  = nv + 1;
      t_v = cyc;
      if (prev_v) wide = wide + 1;
    end
    prev_v = vld;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // nbits < 14 gives a truncated frame; per grows by drift each bit
  task automatic send(input bit s2, input bit tg, input logic [4:0] a,
                      input logic [5:0] c, input int per, input int drift,
                      input int nbits);
    logic [13:0] b;
    int p;
    b = {1'b1, s2, tg, a, c};
    for (int i = 13; i > 13 - nbits; i--) begin
      p  = per + drift * (13 - i);
      rx = b[i];
      repeat (p / 2) @(negedge clk);
      rx = ~b[i];
      if (i == 1) t_mid = cyc;
      repeat (p - p / 2) @(negedge clk);
    end
    rx = 1'b1;
  endtask

  task automatic expect_code(input string req, input int n0, input logic [6:0] ec,
                             input logic [4:0] ea, input bit et);
    chk(nv == n0 + 1, req, "valid count", nv - n0, 1);
    chk(cmd == ec, req, "command", cmd, ec);
    chk(adr == ea, req, "address", adr, ea);
    chk(tog == et, req, "toggle", tog, et);
  endtask

  task automatic t_reset;
    // R1
    chk(vld == 1'b0, "R1", "valid after reset", vld, 0);
    chk(cmd == 7'h0 && adr == 5'h0 && tog == 1'b0, "R1", "outputs after reset",
        {cmd, adr, tog}, 0);
  endtask

  task automatic t_first_zero;
    int n0;
    n0 = nv;
    send(1'b1, 1'b0, 5'h07, 6'h12, T, 0, 14);
    idle(2 * T);
    // R1 R7: stored toggle starts at 0, so this frame is a repeat
    chk(nv == n0, "R7", "first toggle-0 frame dropped", nv - n0, 0);
    chk(cmd == 7'h0, "R1", "command untouched", cmd, 0);
  endtask

  task automatic t_basic;
    int n0, lat;
    n0 = nv;
    send(1'b1, 1'b1, 5'h15, 6'h2A, T, 0, 14);
    idle(2 * T);
    // R2 R3
    expect_code("R3", n0, 7'h2A, 5'h15, 1'b1);
    lat = t_v - t_mid;
    // R8: pulse about 3/4 period after the last mid-bit edge
    chk(lat >= (3 * T) / 4 - 4 && lat <= (3 * T) / 4 + 12, "R8", "latency", lat, (3 * T) / 4);
    chk(wide == 0, "R8", "pulse width", wide, 0);
  endtask

  task automatic t_c6;
    int n0;
    n0 = nv;
    send(1'b0, 1'b0, 5'h0A, 6'h15, T, 0, 14);
    idle(2 * T);
    // R4: second start bit 0 sets command bit 6
    expect_code("R4", n0, 7'h55, 5'h0A, 1'b0);
  endtask

  task automatic t_repeat;
    int n0;
    n0 = nv;
    send(1'b1, 1'b0, 5'h1F, 6'h01, T, 0, 14);
    idle(2 * T);
    // R7 R8
    chk(nv == n0, "R7", "held key dropped", nv - n0, 0);
    chk(cmd == 7'h55 && adr == 5'h0A, "R8", "outputs held", {cmd, adr}, {7'h55, 5'h0A});
  endtask

  task automatic t_rates;
    int n0;
    n0 = nv;
    send(1'b1, 1'b1, 5'h03, 6'h3C, (T * 115) / 100, 0, 14);
    idle(3 * T);
    // R5 slow remote
    expect_code("R5", n0, 7'h3C, 5'h03, 1'b1);
    n0 = nv;
    send(1'b0, 1'b0, 5'h1C, 6'h0F, (T * 85) / 100, 0, 14);
    idle(2 * T);
    // R5 fast remote
    expect_code("R5", n0, 7'h4F, 5'h1C, 1'b0);
  endtask

  task automatic t_drift;
    int n0;
    n0 = nv;
    send(1'b0, 1'b1, 5'h11, 6'h01, (T * 90) / 100, 6, 14);
    idle(3 * T);
    // R5 period drifting within the frame
    expect_code("R5", n0, 7'h41, 5'h11, 1'b1);
  endtask

  task automatic t_trunc;
    int n0;
    n0 = nv;
    send(1'b1, 1'b0, 5'h02, 6'h00, T, 0, 5);
    idle(4 * T);
    // R6
    chk(nv == n0, "R6", "truncated frame silent", nv - n0, 0);
    chk(cmd == 7'h41, "R6", "outputs after abort", cmd, 7'h41);
    n0 = nv;
    send(1'b1, 1'b0, 5'h02, 6'h33, T, 0, 14);
    idle(2 * T);
    // R6: decoder back in idle and stored toggle kept at 1
    expect_code("R6", n0, 7'h33, 5'h02, 1'b0);
  endtask

  task automatic t_back;
    int n0;
    n0 = nv;
    send(1'b1, 1'b1, 5'h0C, 6'h3F, T, 0, 14);
    idle((T * 6) / 10);
    send(1'b0, 1'b0, 5'h19, 6'h21, T, 0, 14);
    idle(2 * T);
    // R9: tail edges of the first frame start nothing
    chk(nv == n0 + 2, "R9", "back-to-back frames", nv - n0, 2);
    chk(cmd == 7'h61 && adr == 5'h19, "R9", "second frame code", {cmd, adr}, {7'h61, 5'h19});
    chk(wide == 0, "R8", "pulse width overall", wide, 0);
  endtask

  initial begin
    rx    = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_zero();
    t_basic();
    t_c6();
    t_repeat();
    t_rates();
    t_drift();
    t_trunc();
    t_back();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule